// File: doc/BRIEF.md
# Hold-Flag Block Decoder

This block expands compressed scan-load data into a serial scan-in stream. A scan load (one test pattern) is divided into `PAT_BLKS` blocks of `BLK_LEN` bits each. Each block arrives as a single control bit. A bit of 0 marks a *transition block*: the decoder copies `BLK_LEN` fresh bits from a pseudo-random source, one per output cycle, and pulses a consume strobe for each bit it takes. A bit of 1 marks a *hold block*: the decoder repeats the last bit it sent in the previous block for the whole block and leaves the random source untouched.

The offline encoder decides how each block is marked. It marks a block as a transition block when the block has both polarities, or when its only specified value differs from the last specified value before it. A block with no specified bits may carry either marking, and the decoder follows whichever bit it receives. At the start of each pattern the repeat value is 0. The control input uses valid/ready. The random source presents a bit with a valid, and output waits whenever either input is not ready. The scan output is registered and carries a valid and an end-of-pattern marker.

Top module: `hold_flag_decoder`

## Requirements
- R1: After a synchronous reset, `scan_valid` is 0, `flag_ready` is 1 and `lfsr_take` is 0.
- R2: For a block whose control bit is 0, the block's `BLK_LEN` scan bits equal, in order, the `lfsr_bit` values present in the cycles where `lfsr_take` pulses. Each such bit appears on `scan_bit` one cycle after its `lfsr_take`.
- R3: For a block whose control bit is 1, every scan bit equals the last scan bit of the previous block in the same pattern. `lfsr_take` stays 0 throughout that block.
- R4: The repeat value is 0 at the start of every pattern, so a hold block that opens a pattern produces all zeros.
- R5: Each accepted control bit yields exactly `BLK_LEN` scan bits, and no scan bit is produced while no control bit is held.
- R6: `lfsr_take` is 1 only in a cycle where `lfsr_valid` is 1 and the current block is a transition block. The total number of consumed bits equals `BLK_LEN` times the number of transition blocks.
- R7: While `lfsr_valid` is 0 during a transition block, no scan bit is produced. The stream resumes without loss or duplication, and the repeat value is kept.
- R8: `scan_last` is 1 exactly on the final bit of each pattern, which is bit `BLK_LEN-1` of block `PAT_BLKS-1`.
- R9: `flag_ready` is 0 from the cycle after a control bit is accepted until that block's last scan bit has been produced. A control bit offered in that window is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flag_valid | input | 1 | Control bit offered |
| flag_bit | input | 1 | Control bit: 0 transition block, 1 hold block |
| flag_ready | output | 1 | Decoder can accept a control bit |
| lfsr_valid | input | 1 | Random source bit available |
| lfsr_bit | input | 1 | Random source bit |
| lfsr_take | output | 1 | Consume strobe for the random source |
| scan_valid | output | 1 | Scan bit valid (registered) |
| scan_bit | output | 1 | Scan-in data bit (registered) |
| scan_last | output | 1 | Final bit of the pattern (registered) |

## Verification
A corrupted repeat register shows up on the first scan bit of the next hold block, as a bit that differs from the previous block's final bit. After a pattern boundary, it shows up as a nonzero bit. A bit counter that drifts gives the wrong number of bits per block. That error is visible at `flag_ready` within one block length and at `scan_last` by the end of the pattern. A block counter fault moves the end-of-pattern marker and breaks the reset to zero at pattern start. Stalls that are handled wrongly lose or repeat source bits. This shows in the consumed-bit count and within a few bits on the stream.

// File: rtl/hfd_pkg.sv
package hfd_pkg;
  typedef enum logic {
    SRC_LFSR = 1'b0,
    SRC_HOLD = 1'b1
  } blk_src_e;
endpackage

// File: rtl/hfd_flag_slot.sv
module hfd_flag_slot
  import hfd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     flag_valid,
  input  logic     flag_bit,
  input  logic     blk_done,
  output logic     flag_ready,
  output logic     have_q,
  output blk_src_e src_q
);
  assign flag_ready = !have_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q <= 1'b0;
      src_q  <= SRC_LFSR;
    end else if (!have_q) begin
      if (flag_valid) begin
        have_q <= 1'b1;
        src_q  <= blk_src_e'(flag_bit);
      end
    end else if (blk_done) begin
      have_q <= 1'b0;
    end
  end

  // R9: once a flag is taken, the slot stays closed on the next cycle
  a_r9_slot_closes: assert property (@(posedge clk) disable iff (rst)
    (flag_valid && flag_ready) |=> !flag_ready);
endmodule

// File: rtl/hfd_counter.sv
module hfd_counter #(
  parameter int BLK_LEN  = 4,
  parameter int PAT_BLKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic step,
  output logic blk_done,
  output logic pat_done
);
  localparam int BIT_W = (BLK_LEN  > 1) ? $clog2(BLK_LEN)  : 1;
  localparam int BLK_W = (PAT_BLKS > 1) ? $clog2(PAT_BLKS) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BLK_LEN - 1);
  localparam logic [BLK_W-1:0] BLK_LAST = BLK_W'(PAT_BLKS - 1);

  logic [BIT_W-1:0] bit_q;
  logic [BLK_W-1:0] blk_q;

  assign blk_done = step && (bit_q == BIT_LAST);
  assign pat_done = blk_done && (blk_q == BLK_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q <= '0;
      blk_q <= '0;
    end else if (step) begin
      if (bit_q == BIT_LAST) begin
        bit_q <= '0;
        blk_q <= (blk_q == BLK_LAST) ? '0 : blk_q + 1'b1;
      end else begin
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  // R8: a pattern end always returns both counters to their origin
  a_r8_pattern_wrap: assert property (@(posedge clk) disable iff (rst)
    pat_done |=> (bit_q == '0) && (blk_q == '0));
  // R5: block counter never leaves its range
  a_r5_blk_range: assert property (@(posedge clk) disable iff (rst)
    blk_q <= BLK_LAST);
endmodule

// File: rtl/hfd_emit.sv
module hfd_emit
  import hfd_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     step,
  input  blk_src_e src,
  input  logic     lfsr_bit,
  input  logic     pat_done,
  output logic     scan_valid,
  output logic     scan_bit,
  output logic     scan_last
);
  logic held_q;
  logic next_bit;

  assign next_bit = (src == SRC_HOLD) ? held_q : lfsr_bit;

  always_ff @(posedge clk) begin
    if (rst) begin
      held_q     <= 1'b0;
      scan_valid <= 1'b0;
      scan_bit   <= 1'b0;
      scan_last  <= 1'b0;
    end else begin
      scan_valid <= step;
      scan_last  <= step && pat_done;
      if (step) begin
        scan_bit <= next_bit;
        held_q   <= pat_done ? 1'b0 : next_bit;
      end
    end
  end

  // R4: after the final bit of a pattern the repeat value is 0
  a_r4_pattern_zero: assert property (@(posedge clk) disable iff (rst)
    (step && pat_done) |=> !held_q);
  // R7: with no output step the repeat value does not move
  a_r7_held_stable: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(held_q));
endmodule

// File: rtl/hold_flag_decoder.sv
module hold_flag_decoder
  import hfd_pkg::*;
#(
  parameter int BLK_LEN  = 4,
  parameter int PAT_BLKS = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic flag_valid,
  input  logic flag_bit,
  output logic flag_ready,
  input  logic lfsr_valid,
  input  logic lfsr_bit,
  output logic lfsr_take,
  output logic scan_valid,
  output logic scan_bit,
  output logic scan_last
);
  logic     have;
  blk_src_e src;
  logic     step;
  logic     blk_done;
  logic     pat_done;

  assign step      = have && ((src == SRC_HOLD) || lfsr_valid);
  assign lfsr_take = have && (src == SRC_LFSR) && lfsr_valid;

  hfd_flag_slot u_slot (
    .clk        (clk),
    .rst        (rst),
    .flag_valid (flag_valid),
    .flag_bit   (flag_bit),
    .blk_done   (blk_done),
    .flag_ready (flag_ready),
    .have_q     (have),
    .src_q      (src)
  );

  hfd_counter #(.BLK_LEN(BLK_LEN), .PAT_BLKS(PAT_BLKS)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .blk_done (blk_done),
    .pat_done (pat_done)
  );

  hfd_emit u_emit (
    .clk        (clk),
    .rst        (rst),
    .step       (step),
    .src        (src),
    .lfsr_bit   (lfsr_bit),
    .pat_done   (pat_done),
    .scan_valid (scan_valid),
    .scan_bit   (scan_bit),
    .scan_last  (scan_last)
  );

  // R2: a consumed source bit is the next scan bit
  a_r2_take_to_scan: assert property (@(posedge clk) disable iff (rst)
    lfsr_take |=> scan_valid && (scan_bit == $past(lfsr_bit)));
  // R3: no source bit is consumed while a hold block is open
  a_r3_hold_no_take: assert property (@(posedge clk) disable iff (rst)
    (!flag_ready && (src == SRC_HOLD)) |-> !lfsr_take);
  // R5: no output without a held flag
  a_r5_no_flag_no_out: assert property (@(posedge clk) disable iff (rst)
    flag_ready |=> !scan_valid);
endmodule

// File: tb/hold_flag_decoder_tb.sv
module hold_flag_decoder_tb;
  localparam int BLK_LEN  = 4;
  localparam int PAT_BLKS = 3;
  localparam int NPAT     = 8;
  localparam int NDIR     = 3;
  localparam int NBLK     = NPAT * PAT_BLKS + NDIR;
  localparam int NBITS    = NBLK * BLK_LEN;
  // [3] = stall the source, [2:0] = flags of blocks 0..2 (bit 0 first)
  localparam logic [3:0] VEC [NPAT] = '{
    4'b0000, 4'b0111, 4'b0010, 4'b0101,
    4'b1110, 4'b1011, 4'b0001, 4'b1100
  };
  localparam logic DIR_FLAGS [NDIR] = '{1'b1, 1'b0, 1'b1};

  logic clk = 0, rst = 1;
  logic flag_valid = 0, flag_bit = 0, flag_ready;
  logic lfsr_valid = 0, lfsr_bit = 0, lfsr_take;
  logic scan_valid, scan_bit, scan_last;
  always #2.5 clk = ~clk;

  hold_flag_decoder #(.BLK_LEN(BLK_LEN), .PAT_BLKS(PAT_BLKS)) u_dut (
    .clk(clk), .rst(rst), .flag_valid(flag_valid), .flag_bit(flag_bit),
    .flag_ready(flag_ready), .lfsr_valid(lfsr_valid), .lfsr_bit(lfsr_bit),
    .lfsr_take(lfsr_take), .scan_valid(scan_valid), .scan_bit(scan_bit),
    .scan_last(scan_last));

  int compared = 0, mismatched = 0;
  int src_idx = 0, out_idx = 0, cyc = 0, exp_takes = 0;
  logic stall = 0, take_seen = 0, monitor_on = 0;
  logic exp_bit [NBITS];

  function automatic logic src_of(int i);
    return logic'(((i * 13 + (i >> 2)) >> 1) & 1);
  endfunction

  task automatic check(string req, logic act, logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0b expected %0b (out %0d)", req, act, exp, out_idx);
    end
  endtask

  function automatic logic flag_of(int b);
    if (b < NPAT * PAT_BLKS) return VEC[b / PAT_BLKS][b % PAT_BLKS];
    return DIR_FLAGS[b - NPAT * PAT_BLKS];
  endfunction

  // expected stream built from the requirements
  initial begin
    logic held = 0;
    int n = 0;
    for (int b = 0; b < NBLK; b++) begin
      if (b % PAT_BLKS == 0) held = 0;                 // R4
      for (int k = 0; k < BLK_LEN; k++) begin
        if (!flag_of(b)) begin held = src_of(n); n++; end  // R2
        exp_bit[b * BLK_LEN + k] = held;                    // R3
      end
    end
    exp_takes = n;
  end

  // random source model and R6/R7 strobe checks
  always @(negedge clk) begin
    cyc++;
    if (take_seen) src_idx++;
    lfsr_valid = !(stall && (cyc % 3 == 0));
    lfsr_bit   = src_of(src_idx);
    #1;
    take_seen = lfsr_take;
    if (lfsr_take && !lfsr_valid) check("R7 take while source stalled", lfsr_take, 1'b0);
  end

  // scan monitor: R2, R3, R4, R5, R8
  always @(negedge clk) begin
    if (monitor_on && scan_valid) begin
      if (out_idx < NBITS) begin
        check("R2/R3/R4 scan bit", scan_bit, exp_bit[out_idx]);
        check("R8 scan_last", scan_last, logic'((out_idx % (BLK_LEN * PAT_BLKS)) == BLK_LEN * PAT_BLKS - 1));
      end else check("R5 extra scan bit", 1'b1, 1'b0);
      out_idx++;
    end
  end

  task automatic send_flag(logic b);
    @(negedge clk);
    while (!flag_ready) @(negedge clk);
    flag_valid = 1; flag_bit = b;
    @(negedge clk);
    flag_valid = 0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    check("watchdog expired", 1'b1, 1'b0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    @(negedge clk);
    // R1: reset state
    check("R1 scan_valid", scan_valid, 1'b0);
    check("R1 flag_ready", flag_ready, 1'b1);
    check("R1 lfsr_take", lfsr_take, 1'b0);
    monitor_on = 1;
    // table walk
    for (int p = 0; p < NPAT; p++) begin
      stall = VEC[p][3];
      for (int b = 0; b < PAT_BLKS; b++) send_flag(VEC[p][b]);
    end
    // directed: hold block opening a new pattern (R4), early flag (R9)
    send_flag(DIR_FLAGS[0]);
    while (flag_ready) @(negedge clk);
    stall = 0;
    flag_valid = 1; flag_bit = DIR_FLAGS[1];
    for (int i = 0; i < BLK_LEN - 1; i++) begin
      check("R9 ready low in block", flag_ready, 1'b0);
      @(negedge clk);
    end
    while (!flag_ready) @(negedge clk);
    @(negedge clk);
    flag_valid = 0;
    check("R9 ready low after accept", flag_ready, 1'b0);
    send_flag(DIR_FLAGS[2]);
    repeat (4 * BLK_LEN + 8) @(negedge clk);
    check("R5 total scan bits", logic'(out_idx == NBITS), 1'b1);
    check("R6 consumed source bits", logic'(src_idx == exp_takes), 1'b1);
    check("R5 idle ready", flag_ready, 1'b1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule